// File: doc/BRIEF.md
# Flash Word Program-Verify Sequencer

This block programs a run of consecutive flash words without processor help. A start strobe supplies a byte start address, a word count and a width choice: single 16-bit words, or even/odd pairs written as one 32-bit unit. The sequencer puts the array into program mode through its control register and waits for the high voltage to settle. It then checks the supply, and pulses each word with a single-cycle array write until a margin-verify read returns the expected data.

A verify is two read strobes to the same address with a fixed gap between them. Only the second read is compared. Each word has its own pulse budget, counted before every pulse. After each pulse the sequencer waits for the array's busy flag to drop and then samples the array's fault flag. The run always ends by writing zero to the control register, so the array leaves program mode. It then reports success, pulse-limit failure or supply failure. Expected data comes from the data source combinationally, for the address shown on `cur_addr`.

Top module: `flash_pv_seq`

## Requirements
- R1: After reset, `active`, `done`, `ctl_we`, `arr_we`, `arr_re`, `fail_limit` and `fail_supply` are all low.
- R2: A start strobe in idle writes the control register with bit 0 (enable) set and bit 1 equal to the 32-bit mode choice. At least SETTLE_CYC+1 cycles then pass before the first array write.
- R3: If `supply_ok` is low when the settle wait ends, the run ends with `fail_supply` and makes no array write.
- R4: A word count of zero ends the run successfully with no array write.
- R5: Each pulse is a one-cycle array write of the expected data to the word's address. A word is re-pulsed until its verify passes, so the array ends up holding the expected data.
- R6: A verify issues two read strobes to the same address, the second VERIFY_CYC+1 cycles after the first. Only the data returned with the second strobe is compared.
- R7: In 32-bit mode a pulse writes the even word (address A) and then the odd word (A+2). Verify reads A first and then A+2. A mismatch on either word re-pulses both.
- R8: The pulse count restarts at zero for every word and is incremented before each pulse. When the next increment would reach MAX_PULSES, the run ends with `fail_limit`, so a word receives at most MAX_PULSES-1 pulses.
- R9: After a pulse the sequencer waits for `busy` to be low and then samples `fault`. If `fault` is high, the run ends with `fail_supply` and no further write is made.
- R10: After a word verifies, the address advances by 2 in 16-bit mode and by 4 in 32-bit mode, until the word count is used up.
- R11: Every run ends with a control register write of zero, followed one cycle later by a one-cycle `done`. `fail_limit` and `fail_supply` are never both high, and they hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, taken only in idle |
| base_addr | input | AW | Byte address of the first word |
| word_cnt | input | CW | Number of words (16-bit) or pairs (32-bit) |
| wide_mode | input | 1 | 1 selects 32-bit pair programming |
| supply_ok | input | 1 | High voltage present, checked after settling |
| busy | input | 1 | Array is applying a pulse |
| fault | input | 1 | Supply dropped during the last pulse |
| src_lo | input | DW | Expected data for `cur_addr` |
| src_hi | input | DW | Expected data for `cur_addr`+2 |
| rd_data | input | DW | Array read data, valid with `arr_re` |
| cur_addr | output | AW | Address of the word in progress |
| ctl_we | output | 1 | Control register write strobe |
| ctl_wdata | output | 2 | Control value: bit 0 enable, bit 1 32-bit mode |
| arr_we | output | 1 | Array write strobe (starts a pulse) |
| arr_re | output | 1 | Array verify read strobe |
| arr_addr | output | AW | Array write/read address |
| arr_wdata | output | DW | Array write data |
| active | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail_limit | output | 1 | Last run hit the pulse limit |
| fail_supply | output | 1 | Last run saw a supply problem |

## Verification
The bench sweeps both widths, word counts of zero to three and several start addresses against an array model. In this model each word needs a known number of pulses, and a read returns correct data only as the second read of a pair, with no write between them and a full gap before it. A design that compared the first read, or shortened the gap, would re-pulse until it hit the limit. A wrong stride would leave the counted pulses on the wrong words.

Pairs whose halves need different pulse counts show whether both halves are re-pulsed together. A word that needs exactly MAX_PULSES-1 pulses and one that needs more bracket the off-by-one in the pulse limit. Supply low at the check, a fault flag after the first pulse, and a zero count each confirm that no stray write is made and that program mode is still exited.

// File: rtl/wps_pkg.sv
package wps_pkg;
   localparam int CTL_W    = 2;
   localparam int CTL_EN   = 0;
   localparam int CTL_WIDE = 1;

   typedef enum logic [3:0] {
      S_IDLE, S_CFG, S_SETTLE, S_SUPCHK, S_PINC, S_WLO, S_WHI,
      S_BUSY, S_RD1, S_GAP, S_RD2, S_EXIT, S_DONE
   } wps_state_e;
endpackage

// File: rtl/wps_delay.sv
module wps_delay #(
   parameter int LW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [LW-1:0] limit,
   output logic          hit
);
   logic [LW-1:0] cnt_q;

   assign hit = run && (cnt_q == limit - LW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else if (!hit)   cnt_q <= cnt_q + LW'(1);
   end

   // R2
   cnt_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q < limit));
endmodule

// File: rtl/wps_pulse_ctr.sv
module wps_pulse_ctr #(
   parameter int MAX_PULSES = 390
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic at_cap
);
   localparam int PW = $clog2(MAX_PULSES + 1);
   logic [PW-1:0] cnt_q;

   assign at_cap = (cnt_q == PW'(MAX_PULSES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + PW'(1);
   end

   // R8
   pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < PW'(MAX_PULSES));
endmodule

// File: rtl/wps_addr_gen.sv
module wps_addr_gen #(
   parameter int AW = 16,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic [CW-1:0] count,
   input  logic          step,
   input  logic          wide,
   output logic [AW-1:0] addr,
   output logic          last,
   output logic          empty
);
   logic [CW-1:0] rem_q;

   assign last  = (rem_q == CW'(1));
   assign empty = (rem_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr  <= '0;
         rem_q <= '0;
      end else if (load) begin
         addr  <= base;
         rem_q <= count;
      end else if (step) begin
         addr  <= addr + (wide ? AW'(4) : AW'(2));
         rem_q <= rem_q - CW'(1);
      end
   end

   // R10
   step_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> !empty);
endmodule

// File: rtl/flash_pv_seq.sv
module flash_pv_seq import wps_pkg::*; #(
   parameter int AW         = 16,
   parameter int CW         = 8,
   parameter int DW         = 16,
   parameter int SETTLE_CYC = 200,
   parameter int VERIFY_CYC = 80,
   parameter int MAX_PULSES = 390,
   parameter bit WIDE_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [AW-1:0]    base_addr,
   input  logic [CW-1:0]    word_cnt,
   input  logic             wide_mode,
   input  logic             supply_ok,
   input  logic             busy,
   input  logic             fault,
   input  logic [DW-1:0]    src_lo,
   input  logic [DW-1:0]    src_hi,
   input  logic [DW-1:0]    rd_data,
   output logic [AW-1:0]    cur_addr,
   output logic             ctl_we,
   output logic [CTL_W-1:0] ctl_wdata,
   output logic             arr_we,
   output logic             arr_re,
   output logic [AW-1:0]    arr_addr,
   output logic [DW-1:0]    arr_wdata,
   output logic             active,
   output logic             done,
   output logic             fail_limit,
   output logic             fail_supply
);
   localparam int DLY_MAX = (SETTLE_CYC > VERIFY_CYC) ? SETTLE_CYC : VERIFY_CYC;
   localparam int LW      = $clog2(DLY_MAX + 1);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("SETTLE_CYC must be at least 1");
   end
   if (VERIFY_CYC < 1) begin : g_bad_verify
      $error("VERIFY_CYC must be at least 1");
   end
   if (MAX_PULSES < 2) begin : g_bad_max
      $error("MAX_PULSES must be at least 2");
   end
   if (AW < 3 || DW < 1 || CW < 1) begin : g_bad_width
      $error("address, data or count width too small");
   end

   wps_state_e st_q, st_d;
   logic       half_q, half_d;
   logic       flim_d, fsup_d;
   logic       wide_sel;
   logic       dly_run, dly_hit;
   logic [LW-1:0] dly_lim;
   logic       p_clr, p_inc, p_cap;
   logic       a_load, a_step, a_last, a_empty;
   logic       prog_on_q;
   logic [DW-1:0] exp_data;

   // 32-bit support is a build option: without it the mode input is ignored
   if (WIDE_EN) begin : g_wide
      logic mode_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        mode_q <= 1'b0;
         else if (st_q == S_IDLE && start)  mode_q <= wide_mode;
      end
      assign wide_sel = mode_q;
   end else begin : g_narrow
      logic unused_mode;
      assign unused_mode = wide_mode;
      assign wide_sel    = 1'b0;
   end

   wps_delay #(.LW(LW)) u_dly (
      .clk(clk), .rst_n(rst_n), .run(dly_run), .limit(dly_lim), .hit(dly_hit)
   );

   wps_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_pctr (
      .clk(clk), .rst_n(rst_n), .clr(p_clr), .inc(p_inc), .at_cap(p_cap)
   );

   wps_addr_gen #(.AW(AW), .CW(CW)) u_agen (
      .clk(clk), .rst_n(rst_n), .load(a_load), .base(base_addr), .count(word_cnt),
      .step(a_step), .wide(wide_sel), .addr(cur_addr), .last(a_last), .empty(a_empty)
   );

   assign dly_run  = (st_q == S_SETTLE) || (st_q == S_GAP);
   assign dly_lim  = (st_q == S_SETTLE) ? LW'(SETTLE_CYC) : LW'(VERIFY_CYC);
   assign exp_data = half_q ? src_hi : src_lo;
   assign active   = (st_q != S_IDLE);

   always_comb begin
      st_d      = st_q;
      half_d    = half_q;
      flim_d    = fail_limit;
      fsup_d    = fail_supply;
      p_clr     = 1'b0;
      p_inc     = 1'b0;
      a_load    = 1'b0;
      a_step    = 1'b0;
      ctl_we    = 1'b0;
      ctl_wdata = '0;
      arr_we    = 1'b0;
      arr_re    = 1'b0;
      arr_addr  = cur_addr;
      arr_wdata = src_lo;
      done      = 1'b0;
      unique case (st_q)
         S_IDLE: begin
            if (start) begin
               a_load = 1'b1;
               flim_d = 1'b0;
               fsup_d = 1'b0;
               st_d   = S_CFG;
            end
         end
         S_CFG: begin
            ctl_we              = 1'b1;
            ctl_wdata[CTL_EN]   = 1'b1;
            ctl_wdata[CTL_WIDE] = wide_sel;
            st_d                = S_SETTLE;
         end
         S_SETTLE: if (dly_hit) st_d = S_SUPCHK;
         S_SUPCHK: begin
            p_clr = 1'b1;
            if (!supply_ok) begin
               fsup_d = 1'b1;
               st_d   = S_EXIT;
            end else if (a_empty) begin
               st_d = S_EXIT;
            end else begin
               st_d = S_PINC;
            end
         end
         S_PINC: begin
            half_d = 1'b0;
            if (p_cap) begin
               flim_d = 1'b1;
               st_d   = S_EXIT;
            end else begin
               p_inc = 1'b1;
               st_d  = S_WLO;
            end
         end
         S_WLO: begin
            arr_we = 1'b1;
            st_d   = wide_sel ? S_WHI : S_BUSY;
         end
         S_WHI: begin
            arr_we    = 1'b1;
            arr_addr  = cur_addr + AW'(2);
            arr_wdata = src_hi;
            st_d      = S_BUSY;
         end
         S_BUSY: begin
            if (!busy) begin
               if (fault) begin
                  fsup_d = 1'b1;
                  st_d   = S_EXIT;
               end else begin
                  st_d = S_RD1;
               end
            end
         end
         S_RD1: begin
            arr_re   = 1'b1;
            arr_addr = cur_addr + (half_q ? AW'(2) : AW'(0));
            st_d     = S_GAP;
         end
         S_GAP: if (dly_hit) st_d = S_RD2;
         S_RD2: begin
            arr_re   = 1'b1;
            arr_addr = cur_addr + (half_q ? AW'(2) : AW'(0));
            if (rd_data != exp_data) begin
               st_d = S_PINC;
            end else if (wide_sel && !half_q) begin
               half_d = 1'b1;
               st_d   = S_RD1;
            end else if (a_last) begin
               st_d = S_EXIT;
            end else begin
               a_step = 1'b1;
               p_clr  = 1'b1;
               st_d   = S_PINC;
            end
         end
         S_EXIT: begin
            ctl_we = 1'b1;
            st_d   = S_DONE;
         end
         S_DONE: begin
            done = 1'b1;
            st_d = S_IDLE;
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= S_IDLE;
         half_q      <= 1'b0;
         fail_limit  <= 1'b0;
         fail_supply <= 1'b0;
      end else begin
         st_q        <= st_d;
         half_q      <= half_d;
         fail_limit  <= flim_d;
         fail_supply <= fsup_d;
      end
   end

   // program-mode tracker fed only by the control register strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prog_on_q <= 1'b0;
      else if (ctl_we) prog_on_q <= ctl_wdata[CTL_EN];
   end

   // R5
   we_in_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> prog_on_q);

   // R11
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fail_limit, fail_supply}));

   // R11
   exit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(ctl_we) && ($past(ctl_wdata) == '0)));

   // R11
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !active);

   // R6
   no_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(arr_we && arr_re));
endmodule

// File: tb/flash_pv_seq_bench.sv
module flash_pv_seq_bench;
   localparam int AW = 8, CW = 4, DW = 16;
   localparam int SET = 6, VER = 3, MAXP = 4, BUSY_T = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [AW-1:0] base_addr = '0;
   logic [CW-1:0] word_cnt = '0;
   logic wide_mode = 1'b0;
   logic supply_ok = 1'b1;
   logic fault = 1'b0;
   logic busy;
   logic [DW-1:0] src_lo, src_hi, rd_data;
   logic [AW-1:0] cur_addr, arr_addr;
   logic ctl_we, arr_we, arr_re, active, done, fail_limit, fail_supply;
   logic [1:0] ctl_wdata;
   logic [DW-1:0] arr_wdata;

   always #2.5 clk = ~clk;

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
      return 16'h3C5A ^ {a, ~a};
   endfunction

   assign src_lo = pat(cur_addr);
   assign src_hi = pat(cur_addr + 8'd2);

   flash_pv_seq #(.AW(AW), .CW(CW), .DW(DW), .SETTLE_CYC(SET), .VERIFY_CYC(VER),
                  .MAX_PULSES(MAXP), .WIDE_EN(1'b1)) u_flash_pv_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .word_cnt(word_cnt), .wide_mode(wide_mode), .supply_ok(supply_ok),
      .busy(busy), .fault(fault), .src_lo(src_lo), .src_hi(src_hi),
      .rd_data(rd_data), .cur_addr(cur_addr), .ctl_we(ctl_we),
      .ctl_wdata(ctl_wdata), .arr_we(arr_we), .arr_re(arr_re),
      .arr_addr(arr_addr), .arr_wdata(arr_wdata), .active(active),
      .done(done), .fail_limit(fail_limit), .fail_supply(fail_supply)
   );

   // array model
   int pulses [16];
   int need   [16];
   logic [DW-1:0] tgt [16];
   int cyc = 0, busy_cnt = 0, wr_cnt = 0, en_cyc = 0, first_wr = -1;
   int prv_cyc = 0, last_gap = 0, rd_n = 0;
   logic [AW-1:0] prv_addr = '0;
   logic prv_vld = 1'b0, wr_since = 1'b0, mdl_clr = 1'b0;
   logic [1:0] last_ctl = '0, en_val = '0;
   logic [AW-1:0] rdlog [8];

   assign busy = (busy_cnt != 0);

   always_comb begin
      logic [3:0] ri;
      logic armed;
      ri = arr_addr[4:1];
      armed = prv_vld && (prv_addr == arr_addr) && !wr_since && ((cyc - prv_cyc) >= VER + 1);
      rd_data = (armed && pulses[ri] >= need[ri]) ? tgt[ri] : ~pat(arr_addr);
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mdl_clr) begin
         for (int i = 0; i < 16; i++) begin
            pulses[i] <= 0;
            tgt[i]    <= '0;
         end
         busy_cnt <= 0; wr_cnt <= 0; first_wr <= -1; prv_vld <= 1'b0;
         wr_since <= 1'b0; last_gap <= 0; rd_n <= 0; last_ctl <= 2'b11; en_val <= '0;
      end else begin
         if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
         if (arr_we) begin
            pulses[arr_addr[4:1]] <= pulses[arr_addr[4:1]] + 1;
            tgt[arr_addr[4:1]]    <= arr_wdata;
            busy_cnt <= BUSY_T;
            wr_cnt   <= wr_cnt + 1;
            wr_since <= 1'b1;
            if (first_wr < 0) first_wr <= cyc;
         end
         if (ctl_we) begin
            last_ctl <= ctl_wdata;
            if (ctl_wdata[0]) begin
               en_cyc <= cyc;
               en_val <= ctl_wdata;
            end
         end
         if (arr_re) begin
            if (prv_vld && prv_addr == arr_addr) last_gap <= cyc - prv_cyc;
            prv_vld  <= 1'b1;
            prv_addr <= arr_addr;
            prv_cyc  <= cyc;
            wr_since <= 1'b0;
            if (rd_n < 8) rdlog[rd_n] <= arr_addr;
            rd_n <= rd_n + 1;
         end
      end
   end

   int n_chk = 0, n_fail = 0;
   logic got_done;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_need_default();
      for (int i = 0; i < 16; i++) need[i] = (i % 3) + 1;
   endtask

   task automatic run_op(input int base, input int cnt, input bit wide);
      @(negedge clk);
      base_addr = AW'(base); word_cnt = CW'(cnt); wide_mode = wide;
      mdl_clr = 1'b1;
      @(negedge clk);
      mdl_clr = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      got_done = 1'b0;
      for (int t = 0; t < 5000; t++) begin
         @(negedge clk);
         if (done) begin
            got_done = 1'b1;
            break;
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      set_need_default();
      repeat (3) @(negedge clk);
      // R1: idle after reset
      chk(!active && !done && !ctl_we && !arr_we && !arr_re && !fail_limit && !fail_supply,
          "R1 reset state", int'({active, done, ctl_we, arr_we, arr_re, fail_limit, fail_supply}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // sweep widths, counts and bases
      for (int w = 0; w < 2; w++) begin
         for (int c = 1; c <= 3; c++) begin
            for (int b = 0; b <= 8; b += 4) begin
               int stride, exp_wr, touched;
               set_need_default();
               run_op(b, c, w[0]);
               stride = w ? 4 : 2;
               chk(got_done && !fail_limit && !fail_supply, "R5 run completes",
                   int'({got_done, fail_limit, fail_supply}), 4);
               chk(en_val == {w[0], 1'b1}, "R2 control setup value", en_val, {w[0], 1'b1});
               chk(first_wr - en_cyc >= SET + 1, "R2 settle before first pulse",
                   first_wr - en_cyc, SET + 1);
               chk(last_gap == VER + 1, "R6 verify read spacing", last_gap, VER + 1);
               chk(last_ctl == 2'b00, "R11 exit writes zero", last_ctl, 0);
               exp_wr = 0; touched = 0;
               for (int k = 0; k < c; k++) begin
                  int a, i0, ep;
                  a  = b + k * stride;
                  i0 = a >> 1;
                  if (w) begin
                     ep = (need[i0] > need[i0 + 1]) ? need[i0] : need[i0 + 1];
                     chk(pulses[i0] == ep, "R7 even half pulse count", pulses[i0], ep);
                     chk(pulses[i0 + 1] == ep, "R7 odd half pulse count", pulses[i0 + 1], ep);
                     chk(tgt[i0 + 1] == pat(AW'(a + 2)), "R5 odd data stored",
                         int'(tgt[i0 + 1]), int'(pat(AW'(a + 2))));
                     exp_wr += 2 * ep; touched += pulses[i0] + pulses[i0 + 1];
                  end else begin
                     ep = need[i0];
                     chk(pulses[i0] == ep, "R10 word pulse count", pulses[i0], ep);
                     exp_wr += ep; touched += pulses[i0];
                  end
                  chk(tgt[i0] == pat(AW'(a)), "R5 data stored", int'(tgt[i0]), int'(pat(AW'(a))));
               end
               chk(wr_cnt == exp_wr && touched == exp_wr, "R10 no writes off stride", wr_cnt, exp_wr);
            end
         end
      end

      // R7 order: even verified before odd
      set_need_default();
      need[6] = 1; need[7] = 2;
      run_op(12, 1, 1'b1);
      chk(rdlog[0] == 8'd12 && rdlog[1] == 8'd12, "R7 even read first", rdlog[0], 12);
      chk(rdlog[2] == 8'd14, "R7 odd read second", rdlog[2], 14);
      chk(pulses[6] == 2 && pulses[7] == 2, "R7 both halves re-pulsed", pulses[6], 2);

      // R8 boundary: exactly MAXP-1 pulses passes
      set_need_default();
      need[0] = MAXP - 1;
      run_op(0, 1, 1'b0);
      chk(got_done && !fail_limit, "R8 budget edge passes", fail_limit, 0);
      // R8 one more needed: limit failure
      need[0] = MAXP + 5;
      run_op(0, 1, 1'b0);
      chk(got_done && fail_limit && !fail_supply, "R8 pulse limit fail", fail_limit, 1);
      chk(pulses[0] == MAXP - 1, "R8 pulse count at limit", pulses[0], MAXP - 1);
      chk(last_ctl == 2'b00, "R11 exit after limit", last_ctl, 0);
      repeat (5) @(negedge clk);
      chk(fail_limit, "R11 flag held", fail_limit, 1);

      // R3 supply low before first pulse
      set_need_default();
      supply_ok = 1'b0;
      run_op(0, 2, 1'b0);
      chk(got_done && fail_supply && !fail_limit, "R3 supply fail", fail_supply, 1);
      chk(wr_cnt == 0, "R3 no write", wr_cnt, 0);
      chk(last_ctl == 2'b00, "R11 exit after supply fail", last_ctl, 0);
      supply_ok = 1'b1;

      // R9 fault after pulse
      fault = 1'b1;
      run_op(4, 3, 1'b0);
      chk(got_done && fail_supply && !fail_limit, "R9 fault fail", fail_supply, 1);
      chk(wr_cnt == 1, "R9 single pulse only", wr_cnt, 1);
      fault = 1'b0;

      // R4 zero count
      run_op(4, 0, 1'b0);
      chk(got_done && !fail_supply && !fail_limit, "R4 zero count done",
          int'({fail_supply, fail_limit}), 0);
      chk(wr_cnt == 0, "R4 no write", wr_cnt, 0);
      chk(!fail_limit && !fail_supply, "R11 flags cleared by start", int'({fail_limit, fail_supply}), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule